// File: doc/BRIEF.md
# Video Field Sequencer with Subcarrier Phase-Reset Strobes

This block is the timing core of a digital video encoder. It counts pixel clocks along each line and half-lines within each field, using a line length and a field length picked by a 50/60 Hz select. A rolling field index keeps track of where the field sits in the colour-standard sequence. Two reference inputs put the counters back in step with an external sync source. A pulse on `ref_line` loads the pixel counter with a programmable horizontal trigger value. A pulse on `ref_field` loads the half-line counter with a programmable vertical trigger value. A larger trigger value therefore moves every generated timing signal earlier relative to the reference. When no reference arrives, the counters free-run at their nominal lengths.

From the counters the block drives a sync output with several modes: a vertical sync each field, an odd/even field level, or a field-sequence pulse whose period follows the colour standard. It also drives a one-clock strobe that resets the colour-subcarrier phase, with its period set by a mode field, and a vertical blanking flag. The blanking window comes either from programmable line bounds or from a fixed window for the selected system. All settings are loaded through a plain parallel write port.

Top module: `video_field_seq`

## Requirements
- R1: The pixel counter `h_count` runs 0 to LINE_50-1 (1728 clocks per line) when control bit 0 (`sel60`) is 0, and 0 to LINE_60-1 (1716 clocks) when it is 1, then wraps to 0. A half-line lasts half of this line length.
- R2: `hl_count` steps at the end of each half-line. It wraps after FIELD_HL_50 (625) half-lines when `sel60`=0, or after FIELD_HL_60 (525) when `sel60`=1. `field_idx` advances at every field wrap and wraps modulo 4 when PAL (bit 1) and SECAM (bit 2) are both 0, modulo 8 when PAL=1, and modulo 12 when SECAM=1. SECAM takes priority over PAL.
- R3: Writing address 1 stores the horizontal trigger. A value above the current line length minus 1 is clamped to that limit at write time. A `ref_line` pulse loads `h_count` with the stored trigger in the next cycle, and counting then continues from that value. While `ref_line` is high, `hl_count` holds.
- R4: Sync mode (control bits 4:3) selects `sync_out`. In mode 00, `sync_out` is high while `hl_count` < VS_HL (6). In mode 01, `sync_out` equals `field_idx` bit 0. In mode 11, `sync_out` stays low.
- R5: In sync mode 10, `sync_out` pulses for one clock at the first clock of half-line 0 of the field whose `field_idx` is 0. This gives one pulse every 4, 8 or 12 fields, following R2.
- R6: Writing address 2 stores the 5-bit vertical trigger (0 to 31). A `ref_field` pulse loads `hl_count` with that value in the next cycle, capped at the field length minus 1. `h_count` is not affected.
- R7: Phase mode (control bits 6:5) selects periodic strobes on `phase_reset`, each one clock wide. Mode 01 strobes at the first clock of every half-line whose `hl_count` is a multiple of 4. Mode 10 strobes at the start of every 8th field. Mode 11 strobes at the start of every 4th field.
- R8: In phase mode 00 there is no periodic strobe. `phase_reset` follows `ext_phase_req` in the same cycle only when the enable bit (control bit 7) is 1; otherwise the request is ignored.
- R9: `vblank` is computed from line = `hl_count`/2. When control bit 8 is 0, `vblank` is high when line < first-line register (address 3) or line > last-line register (address 4). When bit 8 is 1, `vblank` uses a fixed window instead: lines 23..310 are active when `sel60`=0, and lines 20..262 are active when `sel60`=1.
- R10: After reset, all counters are 0, all control bits are 0, both trigger values are 0, and the line bounds are RST_FIRST/RST_LAST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 horizontal trigger, 2 vertical trigger, 3 first line, 4 last line |
| wr_data | input | 16 | Write data |
| ref_line | input | 1 | Horizontal reference pulse |
| ref_field | input | 1 | Vertical reference pulse |
| ext_phase_req | input | 1 | External subcarrier reset request |
| h_count | output | HW (11) | Pixel position in line |
| hl_count | output | VW (10) | Half-line position in field |
| field_idx | output | 4 | Field position in standard sequence |
| sync_out | output | 1 | Multi-mode sync output |
| phase_reset | output | 1 | Subcarrier phase-reset strobe |
| vblank | output | 1 | Vertical blanking flag |

## Verification
Each result has its own latency. A write or a reference pulse takes effect at the next clock edge, so the bench samples `h_count` and `hl_count` at the falling edge right after the pulse. The sync, strobe and blanking outputs are decoded combinationally from the counters, so they are compared at each falling edge against the counter values seen at that same edge. `phase_reset` in mode 00 is checked one nanosecond after the request changes. The periodic pulses are counted over windows whose length is a whole multiple of their period. The count then does not depend on where in the sequence the window starts.

// File: rtl/video_field_seq.sv
module video_field_seq #(
  parameter int LINE_50      = 1728,
  parameter int LINE_60      = 1716,
  parameter int FIELD_HL_50  = 625,
  parameter int FIELD_HL_60  = 525,
  parameter int VS_HL        = 6,
  parameter int FIX_FIRST_50 = 23,
  parameter int FIX_LAST_50  = 310,
  parameter int FIX_FIRST_60 = 20,
  parameter int FIX_LAST_60  = 262,
  parameter int RST_FIRST    = 23,
  parameter int RST_LAST     = 310,
  localparam int LMAX = (LINE_50 > LINE_60) ? LINE_50 : LINE_60,
  localparam int FMAX = (FIELD_HL_50 > FIELD_HL_60) ? FIELD_HL_50 : FIELD_HL_60,
  localparam int HW = $clog2(LMAX),
  localparam int VW = $clog2(FMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          ref_line,
  input  logic          ref_field,
  input  logic          ext_phase_req,
  output logic [HW-1:0] h_count,
  output logic [VW-1:0] hl_count,
  output logic [3:0]    field_idx,
  output logic          sync_out,
  output logic          phase_reset,
  output logic          vblank
);

  logic          sel60, pal, secam, ext_en, std_blank;
  logic [1:0]    smode, pmode;
  logic [HW-1:0] htrig;
  logic [4:0]    vtrig;
  logic [VW-1:0] first_ln, last_ln;
  logic [HW-1:0] hc;
  logic [VW-1:0] hl;
  logic [3:0]    fc;
  logic [2:0]    f8;

  wire [HW-1:0] line_last  = sel60 ? HW'(LINE_60 - 1) : HW'(LINE_50 - 1);
  wire [HW-1:0] half_last  = sel60 ? HW'(LINE_60 / 2 - 1) : HW'(LINE_50 / 2 - 1);
  wire [HW-1:0] half_first = half_last + 1'b1;
  wire [VW-1:0] field_last = sel60 ? VW'(FIELD_HL_60 - 1) : VW'(FIELD_HL_50 - 1);
  wire [3:0]    seq_last   = secam ? 4'd11 : (pal ? 4'd7 : 4'd3);

  wire h_wrap  = hc >= line_last;
  wire hl_step = h_wrap || (hc == half_last);
  wire hl_wrap = hl >= field_last;

  wire [HW-1:0] htrig_new = (wr_data > 16'(line_last)) ? line_last : wr_data[HW-1:0];
  wire [VW-1:0] vload     = (16'(vtrig) > 16'(field_last)) ? field_last : VW'(vtrig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {std_blank, ext_en, pmode, smode, secam, pal, sel60} <= '0;
      htrig    <= '0;
      vtrig    <= '0;
      first_ln <= VW'(RST_FIRST);
      last_ln  <= VW'(RST_LAST);
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: {std_blank, ext_en, pmode, smode, secam, pal, sel60} <= wr_data[8:0];
        3'd1: htrig    <= htrig_new;
        3'd2: vtrig    <= wr_data[4:0];
        3'd3: first_ln <= wr_data[VW-1:0];
        3'd4: last_ln  <= wr_data[VW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0;
      hl <= '0;
      fc <= '0;
      f8 <= '0;
    end else begin
      if (ref_line) hc <= htrig;
      else          hc <= h_wrap ? '0 : hc + 1'b1;
      if (ref_field) begin
        hl <= vload;
      end else if (!ref_line && hl_step) begin
        if (hl_wrap) begin
          hl <= '0;
          fc <= (fc >= seq_last) ? 4'd0 : fc + 4'd1;
          f8 <= f8 + 3'd1;
        end else begin
          hl <= hl + 1'b1;
        end
      end
    end
  end

  wire          half_start  = (hc == '0) || (hc == half_first);
  wire          field_start = half_start && (hl == '0);
  wire [VW-1:0] line_no     = hl >> 1;

  always_comb begin
    case (smode)
      2'b00:   sync_out = hl < VW'(VS_HL);
      2'b01:   sync_out = fc[0];
      2'b10:   sync_out = field_start && (fc == 4'd0);
      default: sync_out = 1'b0;
    endcase
    case (pmode)
      2'b00:   phase_reset = ext_en && ext_phase_req;
      2'b01:   phase_reset = half_start && (hl[1:0] == 2'b00);
      2'b10:   phase_reset = field_start && (f8 == 3'd0);
      default: phase_reset = field_start && (f8[1:0] == 2'b00);
    endcase
    if (std_blank)
      vblank = sel60 ? (line_no < VW'(FIX_FIRST_60) || line_no > VW'(FIX_LAST_60))
                     : (line_no < VW'(FIX_FIRST_50) || line_no > VW'(FIX_LAST_50));
    else
      vblank = (line_no < first_ln) || (line_no > last_ln);
  end

  assign h_count   = hc;
  assign hl_count  = hl;
  assign field_idx = fc;

endmodule

// File: rtl/vfs_checker.sv
module vfs_checker #(
  parameter int HW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          ref_line,
  input logic          ref_field,
  input logic [HW-1:0] h_count,
  input logic [HW-1:0] line_last,
  input logic [HW-1:0] htrig,
  input logic [3:0]    field_idx,
  input logic [1:0]    smode,
  input logic [1:0]    pmode,
  input logic          sync_out,
  input logic          phase_reset
);

  p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_line && h_count == line_last) |=> (h_count == '0));

  p_field_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    field_idx <= 4'd11);

  p_preload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_line |=> (h_count == $past(htrig)));

  p_mode3_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smode == 2'b11) |-> !sync_out);

  p_fseq_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smode == 2'b10 && sync_out && !ref_line && !ref_field && !wr_en) |=> !sync_out);

  p_strobe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode != 2'b00 && phase_reset && !ref_line && !ref_field && !wr_en) |=> !phase_reset);

endmodule

bind video_field_seq vfs_checker #(.HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ref_line(ref_line), .ref_field(ref_field),
  .h_count(h_count), .line_last(line_last), .htrig(htrig), .field_idx(field_idx),
  .smode(smode), .pmode(pmode), .sync_out(sync_out), .phase_reset(phase_reset)
);

// File: tb/tb_video_field_seq.sv
module tb_video_field_seq;
  localparam int L50 = 32, L60 = 24, F50 = 9, F60 = 7, VS = 2;
  localparam int FF50 = 2, FL50 = 3, FF60 = 1, FL60 = 2, RF = 1, RL = 3;
  localparam int HW = $clog2(L50), VW = $clog2(F50);
  localparam int FLD = F50 * L50 / 2;

  logic clk = 0, rst_n = 0, wr_en = 0, ref_line = 0, ref_field = 0, ext_phase_req = 0;
  logic [2:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [HW-1:0] h_count;
  logic [VW-1:0] hl_count;
  logic [3:0] field_idx;
  logic sync_out, phase_reset, vblank;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  video_field_seq #(.LINE_50(L50), .LINE_60(L60), .FIELD_HL_50(F50), .FIELD_HL_60(F60),
    .VS_HL(VS), .FIX_FIRST_50(FF50), .FIX_LAST_50(FL50), .FIX_FIRST_60(FF60),
    .FIX_LAST_60(FL60), .RST_FIRST(RF), .RST_LAST(RL)) dut (.*);

  // {sel60, htrig written, expected h_count after ref_line}
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{'{0, 5, 5}, '{0, 31, 31}, '{0, 32, 31}, '{0, 100, 31},
                                 '{1, 23, 23}, '{1, 24, 23}, '{1, 30, 23}, '{1, 0, 0}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic int ctl(int s60, int p, int sc, int sm, int pm, int ee, int sb);
    return s60 | (p << 1) | (sc << 2) | (sm << 3) | (pm << 5) | (ee << 7) | (sb << 8);
  endfunction

  task automatic pulse_line();
    ref_line = 1; @(negedge clk); ref_line = 0;
  endtask

  task automatic count_sync(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (sync_out) c++; end
  endtask

  task automatic count_phase(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (phase_reset) c++; end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c, bad, h0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(h_count == 0 && hl_count == 0 && field_idx == 0, "R10 counters", h_count, 0);
    chk(sync_out == 1 && phase_reset == 0 && vblank == 1, "R10 outputs",
        {sync_out, phase_reset, vblank}, 3'b101);
    rst_n = 1;
    repeat (200) @(negedge clk);
    chk(h_count == 200 % L50, "R1 free-run h_count", h_count, 200 % L50);
    chk(hl_count == (200 / (L50 / 2)) % F50, "R2 free-run hl_count", hl_count, 3);
    chk(field_idx == 1, "R2 field_idx", field_idx, 1);

    // R1 60 Hz line length
    wr(0, ctl(1, 0, 0, 0, 0, 0, 0));
    pulse_line();
    repeat (L60) @(negedge clk);
    chk(h_count == 0, "R1 line 60 wrap", h_count, 0);
    repeat (L60 - 1) @(negedge clk);
    chk(h_count == L60 - 1, "R1 line 60 last", h_count, L60 - 1);

    // R3 trigger clamp and preload (table)
    for (int i = 0; i < NV; i++) begin
      int ll;
      ll = VEC[i][0] ? L60 : L50;
      wr(0, ctl(VEC[i][0], 0, 0, 0, 0, 0, 0));
      wr(1, VEC[i][1]);
      pulse_line();
      chk(h_count == VEC[i][2], "R3 preload/clamp", h_count, VEC[i][2]);
      repeat (3) @(negedge clk);
      chk(h_count == (VEC[i][2] + 3) % ll, "R3 free-run after ref", h_count, (VEC[i][2] + 3) % ll);
    end

    // R6 vertical trigger
    wr(0, ctl(0, 0, 0, 0, 0, 0, 0));
    wr(2, 5);
    h0 = h_count; ref_field = 1; @(negedge clk); ref_field = 0;
    chk(hl_count == 5, "R6 vtrig load", hl_count, 5);
    chk(h_count == (h0 + 1) % L50, "R6 h untouched", h_count, (h0 + 1) % L50);
    wr(2, 31);
    ref_field = 1; @(negedge clk); ref_field = 0;
    chk(hl_count == F50 - 1, "R6 vtrig cap", hl_count, F50 - 1);

    // R4 sync modes
    bad = 0;
    for (int i = 0; i < 2 * FLD; i++) begin @(negedge clk); if (sync_out != (hl_count < VS)) bad++; end
    chk(bad == 0, "R4 vsync mode 00", bad, 0);
    wr(0, ctl(0, 0, 0, 1, 0, 0, 0));
    bad = 0;
    for (int i = 0; i < 3 * FLD; i++) begin @(negedge clk); if (sync_out != field_idx[0]) bad++; end
    chk(bad == 0, "R4 frame flag mode 01", bad, 0);
    wr(0, ctl(0, 0, 0, 3, 0, 0, 0));
    count_sync(2 * FLD, c);
    chk(c == 0, "R4 mode 11 quiet", c, 0);

    // R5 field-sequence pulse
    wr(0, ctl(0, 0, 0, 2, 0, 0, 0)); repeat (2 * FLD) @(negedge clk);
    count_sync(24 * FLD, c); chk(c == 6, "R5 every 4th field", c, 6);
    wr(0, ctl(0, 1, 0, 2, 0, 0, 0)); repeat (2 * FLD) @(negedge clk);
    count_sync(24 * FLD, c); chk(c == 3, "R5 every 8th field", c, 3);
    wr(0, ctl(0, 1, 1, 2, 0, 0, 0)); repeat (2 * FLD) @(negedge clk);
    count_sync(24 * FLD, c); chk(c == 2, "R5 every 12th field", c, 2);

    // R7 phase-reset periodic modes
    wr(0, ctl(0, 0, 0, 0, 1, 0, 0));
    count_phase(10 * FLD, c); chk(c == 30, "R7 every 2 lines", c, 30);
    wr(0, ctl(0, 0, 0, 0, 2, 0, 0));
    count_phase(24 * FLD, c); chk(c == 3, "R7 every 8 fields", c, 3);
    wr(0, ctl(0, 0, 0, 0, 3, 0, 0));
    count_phase(24 * FLD, c); chk(c == 6, "R7 every 4 fields", c, 6);

    // R8 external request gating
    wr(0, ctl(0, 0, 0, 0, 0, 0, 0));
    ext_phase_req = 1; #1;
    chk(phase_reset == 0, "R8 request ignored", phase_reset, 0);
    @(negedge clk); ext_phase_req = 0;
    wr(0, ctl(0, 0, 0, 0, 0, 1, 0));
    ext_phase_req = 1; #1;
    chk(phase_reset == 1, "R8 request honoured", phase_reset, 1);
    @(negedge clk); ext_phase_req = 0; #1;
    chk(phase_reset == 0, "R8 request released", phase_reset, 0);

    // R9 blanking
    wr(3, 2); wr(4, 3);
    bad = 0;
    for (int i = 0; i < FLD; i++) begin
      @(negedge clk); if (vblank != ((hl_count / 2) < 2 || (hl_count / 2) > 3)) bad++;
    end
    chk(bad == 0, "R9 programmable window", bad, 0);
    wr(3, 0); wr(4, 0);
    wr(0, ctl(0, 0, 0, 0, 0, 0, 1));
    bad = 0;
    for (int i = 0; i < FLD; i++) begin
      @(negedge clk); if (vblank != ((hl_count / 2) < FF50 || (hl_count / 2) > FL50)) bad++;
    end
    chk(bad == 0, "R9 fixed 50 Hz window", bad, 0);
    wr(0, ctl(1, 0, 0, 0, 0, 0, 1));
    repeat (F50 * L50) @(negedge clk);
    bad = 0;
    for (int i = 0; i < F60 * L60 / 2; i++) begin
      @(negedge clk); if (vblank != ((hl_count / 2) < FF60 || (hl_count / 2) > FL60)) bad++;
    end
    chk(bad == 0, "R9 fixed 60 Hz window", bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule